// File: doc/BRIEF.md
# Multi-Buffered Endpoint Arming Controller

This block keeps the bookkeeping for one bulk data endpoint that has two, three or four packet buffers. The buffers form a ring. The bus side and the processor side each walk the ring in strict round-robin order with their own pointer. A single fill count records how many buffers hold data: data armed and waiting to go out for an IN endpoint, or received packets waiting for service for an OUT endpoint. The full flag, the empty flag and the pending-packet count all come from that fill count.

The processor writes each buffer's byte count as two bytes. The high byte goes into a holding register. The low-byte write commits the whole value. For an IN endpoint that write arms the next free buffer. For an OUT endpoint it hands the oldest serviced buffer back to the bus, and the written value is discarded.

For every bus token the block picks a handshake and reports it one cycle later:
- STALL while the sticky stall bit is set.
- ACK when the bus side owns a usable buffer.
- NAK otherwise.

Top module: `ep_arm_ctrl`

## Requirements
- R1: After reset the block reports pend_cnt 0, flag_empty 1, flag_full 0, stall_q 0 and hs_valid 0, with hs_code 2'b00.
- R2: For an IN endpoint, a cpu_bch_wr stores the upper BC_W-8 bits from cpu_wdata. A following cpu_bcl_wr arms the next buffer with the count {high, cpu_wdata} and raises pend_cnt by one.
- R3: flag_full is 1 exactly when pend_cnt equals the configured depth. An IN ACK that frees a buffer clears flag_full and lowers pend_cnt by one on the same edge.
- R4: With stall_q clear, an IN token is answered NAK (2'b10) when pend_cnt is 0. Otherwise it is answered ACK (2'b01), and hs_len carries the byte count of the oldest armed buffer. Buffers are sent in the order they were armed.
- R5: A cpu_bcl_wr on an IN endpoint while every buffer is armed has no effect: pend_cnt does not change, and the value is never sent.
- R6: For an OUT endpoint, a token is answered ACK while fewer than depth packets are held, and rx_len is stored as that buffer's count. It is answered NAK when all buffers hold packets.
- R7: For an OUT endpoint, cpu_bc shows the count of the oldest unserviced packet. A cpu_bcl_wr with any data releases that packet and lowers pend_cnt. The write is ignored when no packet is held.
- R8: flag_empty is 1 exactly when pend_cnt is 0.
- R9: A cpu_stall_wr loads cpu_wdata[0] into stall_q. While stall_q is 1, every token is answered STALL (2'b11) and moves no buffer. Clearing the bit restores ACK/NAK.
- R10: cfg_depth selects the ring size: 2'd2 gives two buffers, 2'd3 gives three, and any other value gives four. cfg_depth and cfg_dir_in are changed only while rst_n is low.
- R11: hs_valid pulses in the cycle after each tok_valid cycle, and hs_code is 2'b00 when hs_valid is 0. hs_len is 0 except on an IN ACK.
- R12: A cpu_bcl_wr and a token in the same cycle are both judged on the fill level before that edge. An IN endpoint at level 0 gives NAK and ends at 1. An IN endpoint at full gives ACK and ignores the arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_depth | input | 2 | Buffer count select (R10) |
| cpu_wdata | input | 8 | Processor write data |
| cpu_bch_wr | input | 1 | Write high byte-count holding register |
| cpu_bcl_wr | input | 1 | Write low byte count: arm or release a buffer |
| cpu_stall_wr | input | 1 | Load stall bit from cpu_wdata[0] |
| cpu_bc | output | BC_W | Byte count of the buffer at the processor pointer |
| tok_valid | input | 1 | Bus token for this endpoint |
| rx_len | input | BC_W | Received length for an OUT token |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL, 00 idle |
| hs_len | output | BC_W | Byte count to transmit on IN ACK |
| stall_q | output | 1 | Sticky stall bit |
| flag_full | output | 1 | All buffers hold data |
| flag_empty | output | 1 | No buffer holds data |
| pend_cnt | output | CNT_W | Buffers holding data |

## Verification
The hardest case to reach is an arm and a token landing in the same cycle at the two ends of the fill range. That is where an off-by-one in the accept conditions would overflow the ring or send a stale count. The stimulus first drains the ring and then fills it, and at each end it drives cpu_bcl_wr and tok_valid together. It then drains the remaining buffers one token at a time, so the order of the hs_len values shows whether the ignored arm leaked into the ring. Smaller depths and the OUT direction are reached by changing the configuration inputs under reset.

// File: rtl/ep_arm_pkg.sv
package ep_arm_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

endpackage

// File: rtl/ep_ring_ctrl.sv
// Ring ownership: processor pointer, bus pointer and fill count.
module ep_ring_ctrl #(
  parameter int NBUF_MAX = 4,
  localparam int PTR_W = (NBUF_MAX > 1) ? $clog2(NBUF_MAX) : 1,
  localparam int CNT_W = $clog2(NBUF_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] depth,
  input  logic             arm_req,
  input  logic             bus_go,
  output logic             arm_go,
  output logic             bus_ok,
  output logic [PTR_W-1:0] cpu_ptr,
  output logic [PTR_W-1:0] bus_ptr,
  output logic [CNT_W-1:0] filled
);

  logic             cpu_ok;
  logic [PTR_W-1:0] cpu_ptr_nxt;
  logic [PTR_W-1:0] bus_ptr_nxt;
  logic [CNT_W-1:0] filled_nxt;
  logic             not_full;
  logic             not_empty;

  function automatic logic [PTR_W-1:0] wrap_inc(
    input logic [PTR_W-1:0] p,
    input logic [CNT_W-1:0] d
  );
    if (CNT_W'(p) + CNT_W'(1) >= d) return '0;
    return p + PTR_W'(1);
  endfunction

  assign not_full  = (filled < depth);
  assign not_empty = (filled != '0);

  // The processor owns the buffers the bus does not.
  assign cpu_ok = dir_in ? not_full  : not_empty;
  assign bus_ok = dir_in ? not_empty : not_full;
  assign arm_go = arm_req & cpu_ok;

  always_comb begin
    cpu_ptr_nxt = cpu_ptr;
    bus_ptr_nxt = bus_ptr;
    filled_nxt  = filled;
    if (arm_go) cpu_ptr_nxt = wrap_inc(cpu_ptr, depth);
    if (bus_go) bus_ptr_nxt = wrap_inc(bus_ptr, depth);
    if (dir_in) begin
      case ({arm_go, bus_go})
        2'b10:   filled_nxt = filled + CNT_W'(1);
        2'b01:   filled_nxt = filled - CNT_W'(1);
        default: filled_nxt = filled;
      endcase
    end else begin
      case ({bus_go, arm_go})
        2'b10:   filled_nxt = filled + CNT_W'(1);
        2'b01:   filled_nxt = filled - CNT_W'(1);
        default: filled_nxt = filled;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_ptr <= '0;
      bus_ptr <= '0;
      filled  <= '0;
    end else if (arm_go || bus_go) begin
      cpu_ptr <= cpu_ptr_nxt;
      bus_ptr <= bus_ptr_nxt;
      filled  <= filled_nxt;
    end
  end

endmodule

// File: rtl/ep_bc_regs.sv
// Per-buffer byte count storage with one write port and two read ports.
module ep_bc_regs #(
  parameter int NBUF_MAX = 4,
  parameter int BC_W     = 11,
  localparam int PTR_W = (NBUF_MAX > 1) ? $clog2(NBUF_MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [BC_W-1:0]  wr_data,
  input  logic [PTR_W-1:0] cpu_idx,
  output logic [BC_W-1:0]  cpu_cnt,
  input  logic [PTR_W-1:0] bus_idx,
  output logic [BC_W-1:0]  bus_cnt
);

  logic [BC_W-1:0] cnt_q [NBUF_MAX];

  for (genvar b = 0; b < NBUF_MAX; b++) begin : g_buf
    logic sel_en;
    assign sel_en = wr_en && (wr_idx == PTR_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[b] <= '0;
      else if (sel_en) cnt_q[b] <= wr_data;
    end
  end

  assign cpu_cnt = cnt_q[cpu_idx];
  assign bus_cnt = cnt_q[bus_idx];

endmodule

// File: rtl/ep_hs_sel.sv
// Handshake choice per token plus the sticky stall bit.
module ep_hs_sel
  import ep_arm_pkg::*;
#(
  parameter int BC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_in,
  input  logic            tok_valid,
  input  logic            bus_ok,
  input  logic [BC_W-1:0] bus_cnt,
  input  logic            stall_wr,
  input  logic            stall_val,
  output logic            bus_go,
  output logic            stall_q,
  output logic            hs_valid,
  output hs_e             hs_code,
  output logic [BC_W-1:0] hs_len
);

  hs_e             code_nxt;
  logic [BC_W-1:0] len_nxt;
  logic            stall_nxt;

  always_comb begin
    code_nxt = HS_NONE;
    len_nxt  = '0;
    bus_go   = 1'b0;
    if (tok_valid) begin
      if (stall_q) begin
        code_nxt = HS_STALL;
      end else if (bus_ok) begin
        code_nxt = HS_ACK;
        bus_go   = 1'b1;
        if (dir_in) len_nxt = bus_cnt;
      end else begin
        code_nxt = HS_NAK;
      end
    end
  end

  assign stall_nxt = stall_wr ? stall_val : stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q  <= 1'b0;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      hs_len   <= '0;
    end else begin
      stall_q  <= stall_nxt;
      hs_valid <= tok_valid;
      hs_code  <= code_nxt;
      hs_len   <= len_nxt;
    end
  end

endmodule

// File: rtl/ep_arm_ctrl.sv
module ep_arm_ctrl
  import ep_arm_pkg::*;
#(
  parameter int NBUF_MAX      = 4,
  parameter int MAX_PKT_BYTES = 1024,
  localparam int BC_W  = $clog2(MAX_PKT_BYTES) + 1,
  localparam int HI_W  = BC_W - 8,
  localparam int PTR_W = (NBUF_MAX > 1) ? $clog2(NBUF_MAX) : 1,
  localparam int CNT_W = $clog2(NBUF_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dir_in,
  input  logic [1:0]       cfg_depth,
  input  logic [7:0]       cpu_wdata,
  input  logic             cpu_bch_wr,
  input  logic             cpu_bcl_wr,
  input  logic             cpu_stall_wr,
  output logic [BC_W-1:0]  cpu_bc,
  input  logic             tok_valid,
  input  logic [BC_W-1:0]  rx_len,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic [BC_W-1:0]  hs_len,
  output logic             stall_q,
  output logic             flag_full,
  output logic             flag_empty,
  output logic [CNT_W-1:0] pend_cnt
);

  logic [1:0]       rst_sync;
  logic             rst_n_q;
  logic [CNT_W-1:0] depth_n;
  logic [HI_W-1:0]  bch_q;
  logic             arm_go;
  logic             bus_ok;
  logic             bus_go;
  logic [PTR_W-1:0] cpu_ptr;
  logic [PTR_W-1:0] bus_ptr;
  logic [CNT_W-1:0] filled;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [BC_W-1:0]  wr_data;
  logic [BC_W-1:0]  bus_cnt;
  hs_e              hs_code_e;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_q = rst_sync[1];

  always_comb begin
    case (cfg_depth)
      2'd2:    depth_n = CNT_W'(2);
      2'd3:    depth_n = CNT_W'(3);
      default: depth_n = CNT_W'(NBUF_MAX);
    endcase
  end

  // Holding register for the upper part of the byte count.
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q)        bch_q <= '0;
    else if (cpu_bch_wr) bch_q <= cpu_wdata[HI_W-1:0];
  end

  ep_ring_ctrl #(.NBUF_MAX(NBUF_MAX)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .dir_in  (cfg_dir_in),
    .depth   (depth_n),
    .arm_req (cpu_bcl_wr),
    .bus_go  (bus_go),
    .arm_go  (arm_go),
    .bus_ok  (bus_ok),
    .cpu_ptr (cpu_ptr),
    .bus_ptr (bus_ptr),
    .filled  (filled)
  );

  // IN: the processor writes counts when it arms. OUT: the bus writes them on receive.
  always_comb begin
    if (cfg_dir_in) begin
      wr_en   = arm_go;
      wr_idx  = cpu_ptr;
      wr_data = {bch_q, cpu_wdata};
    end else begin
      wr_en   = bus_go;
      wr_idx  = bus_ptr;
      wr_data = rx_len;
    end
  end

  ep_bc_regs #(.NBUF_MAX(NBUF_MAX), .BC_W(BC_W)) u_bc (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cpu_idx (cpu_ptr),
    .cpu_cnt (cpu_bc),
    .bus_idx (bus_ptr),
    .bus_cnt (bus_cnt)
  );

  ep_hs_sel #(.BC_W(BC_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .dir_in    (cfg_dir_in),
    .tok_valid (tok_valid),
    .bus_ok    (bus_ok),
    .bus_cnt   (bus_cnt),
    .stall_wr  (cpu_stall_wr),
    .stall_val (cpu_wdata[0]),
    .bus_go    (bus_go),
    .stall_q   (stall_q),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code_e),
    .hs_len    (hs_len)
  );

  assign hs_code    = hs_code_e;
  assign pend_cnt   = filled;
  assign flag_full  = (filled == depth_n);
  assign flag_empty = (filled == '0);

endmodule

// File: rtl/ep_arm_chk.sv
module ep_arm_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n_q,
  input logic             cfg_dir_in,
  input logic             tok_valid,
  input logic             cpu_bcl_wr,
  input logic             stall_q,
  input logic             hs_valid,
  input logic [1:0]       hs_code,
  input logic             flag_full,
  input logic             flag_empty,
  input logic [CNT_W-1:0] pend_cnt,
  input logic [CNT_W-1:0] depth_n
);

  // R11
  hs_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    $past(rst_n_q) |-> (hs_valid == $past(tok_valid)));

  // R11
  hs_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !hs_valid |-> (hs_code == 2'b00));

  // R9
  stall_answer_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (tok_valid && stall_q) |=> (hs_code == 2'b11));

  // R9
  stall_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (tok_valid && stall_q && !cpu_bcl_wr) |=> $stable(pend_cnt));

  // R4
  in_nak_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (cfg_dir_in && tok_valid && !stall_q && pend_cnt == '0) |=> (hs_code == 2'b10));

  // R3
  full_release_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    ($past(rst_n_q) && $fell(flag_full)) |-> (pend_cnt == $past(pend_cnt) - CNT_W'(1)));

  // R5
  in_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (cfg_dir_in && flag_full && cpu_bcl_wr && !tok_valid) |=> flag_full);

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(flag_full && flag_empty));

  // R10
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    pend_cnt <= depth_n);

endmodule

bind ep_arm_ctrl ep_arm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n_q    (rst_n_q),
  .cfg_dir_in (cfg_dir_in),
  .tok_valid  (tok_valid),
  .cpu_bcl_wr (cpu_bcl_wr),
  .stall_q    (stall_q),
  .hs_valid   (hs_valid),
  .hs_code    (hs_code),
  .flag_full  (flag_full),
  .flag_empty (flag_empty),
  .pend_cnt   (pend_cnt),
  .depth_n    (depth_n)
);

// File: tb/ep_arm_ctrl_tb.sv
module ep_arm_ctrl_tb;

  localparam int BC_W = 11;
  localparam int CNT_W = 3;
  localparam int OP_TOK = 0, OP_BCH = 1, OP_BCL = 2, OP_STALL = 3;
  localparam int ACK = 1, NAK = 2, STL = 3, NON = 0;

  logic clk, rst_n, cfg_dir_in;
  logic [1:0] cfg_depth;
  logic [7:0] cpu_wdata;
  logic cpu_bch_wr, cpu_bcl_wr, cpu_stall_wr, tok_valid;
  logic [BC_W-1:0] rx_len, cpu_bc, hs_len;
  logic hs_valid, stall_q, flag_full, flag_empty;
  logic [1:0] hs_code;
  logic [CNT_W-1:0] pend_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  ep_arm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_depth(cfg_depth),
    .cpu_wdata(cpu_wdata), .cpu_bch_wr(cpu_bch_wr), .cpu_bcl_wr(cpu_bcl_wr),
    .cpu_stall_wr(cpu_stall_wr), .cpu_bc(cpu_bc), .tok_valid(tok_valid),
    .rx_len(rx_len), .hs_valid(hs_valid), .hs_code(hs_code), .hs_len(hs_len),
    .stall_q(stall_q), .flag_full(flag_full), .flag_empty(flag_empty),
    .pend_cnt(pend_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: op[31:29] wd[28:18] hs[17:16] len[15:5] pend[4:2] full[1] empty[0]
  function automatic logic [31:0] mkv(input int op, input int wd, input int hs,
                                      input int len, input int pend,
                                      input int full, input int empty);
    return {op[2:0], wd[10:0], hs[1:0], len[10:0], pend[2:0], full[0], empty[0]};
  endfunction

  // IN endpoint with four buffers: fill, overfill, drain through a pointer wrap.
  localparam int NV = 19;
  localparam logic [31:0] VEC [NV] = '{
    mkv(OP_TOK, 0,    NAK, 0,     0, 0, 1),   // R4 NAK with nothing armed
    mkv(OP_BCH, 1,    NON, 0,     0, 0, 1),   // R2 high byte only
    mkv(OP_BCL, 8'h23,NON, 0,     1, 0, 0),   // R2 arm 0x123
    mkv(OP_BCH, 0,    NON, 0,     1, 0, 0),
    mkv(OP_BCL, 8'h40,NON, 0,     2, 0, 0),   // arm 0x040
    mkv(OP_BCH, 7,    NON, 0,     2, 0, 0),
    mkv(OP_BCL, 8'hFF,NON, 0,     3, 0, 0),   // arm 0x7FF
    mkv(OP_BCL, 8'h05,NON, 0,     4, 1, 0),   // R3 arm 0x705, full
    mkv(OP_BCL, 8'h99,NON, 0,     4, 1, 0),   // R5 ignored
    mkv(OP_TOK, 0,    ACK, 'h123, 3, 0, 0),   // R3 R4
    mkv(OP_TOK, 0,    ACK, 'h040, 2, 0, 0),
    mkv(OP_BCH, 0,    NON, 0,     2, 0, 0),
    mkv(OP_BCL, 8'h11,NON, 0,     3, 0, 0),   // arm 0x011 after wrap
    mkv(OP_TOK, 0,    ACK, 'h7FF, 2, 0, 0),
    mkv(OP_TOK, 0,    ACK, 'h705, 1, 0, 0),
    mkv(OP_TOK, 0,    ACK, 'h011, 0, 0, 1),   // R5 0x799 never sent; R8
    mkv(OP_TOK, 0,    NAK, 0,     0, 0, 1),
    mkv(OP_BCH, 0,    NON, 0,     0, 0, 1),
    mkv(OP_TOK, 0,    NAK, 0,     0, 0, 1)    // R11
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    cpu_bch_wr = 0; cpu_bcl_wr = 0; cpu_stall_wr = 0; tok_valid = 0;
  endtask

  // Drive at a falling edge, pass one rising edge, observe at the next falling edge.
  task automatic do_op(input int op, input int wd);
    case (op)
      OP_TOK:   begin tok_valid = 1; rx_len = wd[10:0]; end
      OP_BCH:   begin cpu_bch_wr = 1; cpu_wdata = wd[7:0]; end
      OP_BCL:   begin cpu_bcl_wr = 1; cpu_wdata = wd[7:0]; end
      default:  begin cpu_stall_wr = 1; cpu_wdata = wd[7:0]; end
    endcase
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_both(input int low, input int rx);
    cpu_bcl_wr = 1; cpu_wdata = low[7:0]; tok_valid = 1; rx_len = rx[10:0];
    @(negedge clk);
    clear_in();
  endtask

  task automatic apply_reset(input logic dir, input logic [1:0] dep);
    rst_n = 0; clear_in(); cpu_wdata = 0; rx_len = 0;
    cfg_dir_in = dir; cfg_depth = dep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_state(input string tag, input int hs, input int len,
                           input int pend, input int full, input int empty);
    chk({tag, " hs_code"}, hs_code, hs);
    chk({tag, " hs_valid"}, hs_valid, (hs != NON) ? 1 : 0);
    chk({tag, " hs_len"}, hs_len, len);
    chk({tag, " pend_cnt"}, pend_cnt, pend);
    chk({tag, " flag_full"}, flag_full, full);
    chk({tag, " flag_empty"}, flag_empty, empty);
  endtask

  initial begin
    int wd;
    @(negedge clk);
    apply_reset(1'b1, 2'd0);
    // R1 reset state
    chk_state("R1 reset", NON, 0, 0, 0, 1);
    chk("R1 stall_q", stall_q, 0);

    for (int i = 0; i < NV; i++) begin
      wd = int'(VEC[i][28:18]);
      do_op(int'(VEC[i][31:29]), wd);
      chk_state($sformatf("R2/R3/R4/R5 vec%0d", i), int'(VEC[i][17:16]),
                int'(VEC[i][15:5]), int'(VEC[i][4:2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end

    // R9 stall overrides ACK and moves nothing
    do_op(OP_BCL, 8'h22);
    chk("R2 pend after arm", pend_cnt, 1);
    do_op(OP_STALL, 1);
    chk("R9 stall_q set", stall_q, 1);
    do_op(OP_TOK, 0);
    chk_state("R9 stalled", STL, 0, 1, 0, 0);
    do_op(OP_TOK, 0);
    chk_state("R9 still stalled", STL, 0, 1, 0, 0);
    do_op(OP_STALL, 0);
    chk("R9 stall_q clear", stall_q, 0);
    do_op(OP_TOK, 0);
    chk_state("R9 after clear", ACK, 'h022, 0, 0, 1);

    // R12 simultaneous arm and token at both ends
    do_both(8'h31, 0);
    chk_state("R12 empty both", NAK, 0, 1, 0, 0);
    do_op(OP_BCL, 8'h32);
    do_op(OP_BCL, 8'h33);
    do_op(OP_BCL, 8'h34);
    chk("R3 full at four", flag_full, 1);
    do_both(8'h35, 0);
    chk_state("R12 full both", ACK, 'h031, 3, 0, 0);
    do_op(OP_TOK, 0); chk("R12 order 32", hs_len, 'h032);
    do_op(OP_TOK, 0); chk("R12 order 33", hs_len, 'h033);
    do_op(OP_TOK, 0); chk("R12 order 34", hs_len, 'h034);
    do_op(OP_TOK, 0); chk_state("R12 drained", NAK, 0, 0, 0, 1);

    // R10 three-buffer IN ring
    apply_reset(1'b1, 2'd3);
    chk_state("R1 reset d3", NON, 0, 0, 0, 1);
    do_op(OP_BCH, 2);
    do_op(OP_BCL, 1); do_op(OP_BCL, 2);
    chk("R10 d3 not full at 2", flag_full, 0);
    do_op(OP_BCL, 3);
    chk("R10 d3 full at 3", flag_full, 1);
    do_op(OP_BCL, 4);
    chk("R5 d3 ignored", pend_cnt, 3);
    do_op(OP_TOK, 0); chk("R10 d3 first", hs_len, 'h201);
    do_op(OP_TOK, 0); chk("R10 d3 second", hs_len, 'h202);
    do_op(OP_TOK, 0); chk("R10 d3 third", hs_len, 'h203);
    do_op(OP_TOK, 0); chk("R5 d3 no extra", hs_code, NAK);

    // R6 R7 OUT endpoint with two buffers
    apply_reset(1'b0, 2'd2);
    chk_state("R1 reset out", NON, 0, 0, 0, 1);
    do_op(OP_BCL, 8'h55);
    chk("R7 release ignored when empty", pend_cnt, 0);
    do_op(OP_TOK, 'h100);
    chk_state("R6 rx1", ACK, 0, 1, 0, 0);
    chk("R7 cpu_bc rx1", cpu_bc, 'h100);
    do_op(OP_TOK, 'h3FF);
    chk_state("R6 rx2 full", ACK, 0, 2, 1, 0);
    do_op(OP_TOK, 'h00A);
    chk_state("R6 NAK when full", NAK, 0, 2, 1, 0);
    do_op(OP_BCL, 8'hA5);
    chk_state("R7 release one", NON, 0, 1, 0, 0);
    chk("R7 cpu_bc next", cpu_bc, 'h3FF);
    do_op(OP_BCL, 0);
    chk_state("R7 release two", NON, 0, 0, 0, 1);
    do_op(OP_TOK, 'h005);
    chk("R7 cpu_bc after wrap", cpu_bc, 'h005);
    do_op(OP_TOK, 'h006);
    chk("R10 d2 full", flag_full, 1);
    do_both(0, 'h007);
    chk_state("R12 out full both", NAK, 0, 1, 0, 0);
    chk("R7 cpu_bc oldest", cpu_bc, 'h006);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule